// File: doc/BRIEF.md
# Loadable Jerk-Driven Trajectory Integrator

This block produces a position setpoint by playing back a stored move profile. It chains three integrators, jerk into acceleration, acceleration into velocity and velocity into position, and advances them by one step on each clock where the cycle-enable strobe is high. A profile is a list of segments. Each segment has a type, a value, a length in integrator steps, and the acceleration, velocity and position the axis must have when the segment ends.

Segments are written one at a time through a valid/ready port while the block is idle. A start pulse plays them back in the order they were written. On the step that closes a segment, the three state registers take that segment's end values instead of the integrated result. This keeps precision drift from carrying over from one segment to the next. It also lets a constant-velocity phase force the velocity register directly. When the last segment closes, the block raises done for one clock and stops. It holds the position and clears velocity and acceleration to zero. The segment store is then empty and ready for the next profile.

Jerk, acceleration and velocity are 32-bit two's complement values. Position is a 48-bit two's complement integer in fine units, such as 1/32768 of a turn, so that long slow moves lose no resolution.

Top module: `traj_integrator`

## Requirements
- R1: After reset, acceleration, velocity and position read 0, busy and done are low, and seg_ready is high.
- R2: A segment is stored on a clock where seg_valid and seg_ready are both high. seg_ready is low while busy, and low once NSEG segments are held. A seg_valid offered while seg_ready is low stores nothing.
- R3: A start pulse while idle with at least one segment stored sets busy on the next clock and plays back from the first stored segment. A start pulse while busy, or while the store is empty, has no effect.
- R4: The outputs change only on clocks where busy is high. Apart from zero-length segments (R9), they change only on clocks where cyc_en is also high. With cyc_en low, or while idle, acceleration, velocity and position hold their values.
- R5: seg_type 0 is constant jerk with value j. One step sets a' = a + j, v' = v + a', p' = p + v'.
- R6: seg_type 1 is constant acceleration with value c. One step sets a' = c, v' = v + c, p' = p + v'.
- R7: seg_type 2 is constant velocity with value w. One step sets a' = 0, v' = w, p' = p + w.
- R8: A segment of length n > 0 takes n enabled steps. On its n-th step, acceleration, velocity and position take the segment's stored end values in place of the integrated values. Play then moves to the next segment.
- R9: A segment of length 0 performs no integration. On the next clock after it is reached, its end values are loaded without waiting for cyc_en, and play moves on. A cyc_en pulse on that clock is not used as a step.
- R10: When the last stored segment closes, done is high for exactly one clock, busy falls, position takes the end position, and acceleration and velocity become 0. The store is emptied and seg_ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | Segment offered on the load port |
| seg_ready | output | 1 | Block can accept a segment |
| seg_type | input | 2 | 0 constant jerk, 1 constant acceleration, 2 constant velocity |
| seg_value | input | 32 | Jerk, acceleration or velocity of the segment |
| seg_dur | input | 16 | Segment length in integrator steps |
| seg_end_acc | input | 32 | Acceleration at segment end |
| seg_end_vel | input | 32 | Velocity at segment end |
| seg_end_pos | input | 48 | Position at segment end |
| start | input | 1 | Begin playing the stored profile |
| cyc_en | input | 1 | Integrator step strobe |
| acc_o | output | 32 | Acceleration state |
| vel_o | output | 32 | Velocity state |
| pos_o | output | 48 | Position setpoint |
| busy | output | 1 | Profile playback in progress |
| done | output | 1 | One-clock pulse when playback ends |

## Verification
The hardest case to reach is a zero-length segment. It consumes a clock with no step strobe, and that clock falls between two strobes. The stimulus places one such segment between two ordinary segments and another at the end of a profile. It leaves a quiet clock before every strobe so the skip happens there. Outputs are checked right after the skip, and again after the next step, which must integrate from the loaded end values. A full store followed by an extra offered segment, and start pulses sent in the middle of playback, show through the final position and through the done timing that nothing extra was taken.

// File: rtl/traj_integrator.sv
module traj_integrator #(
  parameter int NSEG = 8,
  parameter int DW   = 16,
  parameter int VW   = 32,
  parameter int PW   = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seg_valid,
  output logic                 seg_ready,
  input  logic [1:0]           seg_type,
  input  logic [VW-1:0]        seg_value,
  input  logic [DW-1:0]        seg_dur,
  input  logic [VW-1:0]        seg_end_acc,
  input  logic [VW-1:0]        seg_end_vel,
  input  logic [PW-1:0]        seg_end_pos,
  input  logic                 start,
  input  logic                 cyc_en,
  output logic signed [VW-1:0] acc_o,
  output logic signed [VW-1:0] vel_o,
  output logic signed [PW-1:0] pos_o,
  output logic                 busy,
  output logic                 done
);
  localparam int IW = $clog2(NSEG + 1);
  localparam int AW = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [1:0]    m_type [NSEG];
  logic [VW-1:0] m_val  [NSEG];
  logic [DW-1:0] m_dur  [NSEG];
  logic [VW-1:0] m_ea   [NSEG];
  logic [VW-1:0] m_ev   [NSEG];
  logic [PW-1:0] m_ep   [NSEG];

  logic [IW-1:0] wr_cnt, rd_idx;
  logic [DW-1:0] step_cnt;

  logic [AW-1:0] ci;
  assign ci = rd_idx[AW-1:0];

  logic signed [VW-1:0] cval;
  assign cval = m_val[ci];

  assign seg_ready = !busy && (wr_cnt != IW'(NSEG));

  logic skip, adv, last_step, seg_end, fin;
  assign skip      = busy && (m_dur[ci] == '0);
  assign adv       = busy && cyc_en && !skip;
  assign last_step = adv && (DW'(step_cnt + 1'b1) == m_dur[ci]);
  assign seg_end   = skip || last_step;
  assign fin       = seg_end && (rd_idx == IW'(wr_cnt - 1'b1));

  logic signed [VW-1:0] a_nx, v_nx;
  logic signed [PW-1:0] p_nx;

  always_comb begin
    a_nx = acc_o;
    v_nx = vel_o;
    case (m_type[ci])
      2'd0: begin a_nx = acc_o + cval; v_nx = vel_o + a_nx; end
      2'd1: begin a_nx = cval;         v_nx = vel_o + cval; end
      2'd2: begin a_nx = '0;           v_nx = cval;         end
      default: ;
    endcase
    p_nx = pos_o + {{(PW-VW){v_nx[VW-1]}}, v_nx};
  end

  always_ff @(posedge clk) begin
    if (seg_valid && seg_ready) begin
      m_type[wr_cnt[AW-1:0]] <= seg_type;
      m_val[wr_cnt[AW-1:0]]  <= seg_value;
      m_dur[wr_cnt[AW-1:0]]  <= seg_dur;
      m_ea[wr_cnt[AW-1:0]]   <= seg_end_acc;
      m_ev[wr_cnt[AW-1:0]]   <= seg_end_vel;
      m_ep[wr_cnt[AW-1:0]]   <= seg_end_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o <= '0; vel_o <= '0; pos_o <= '0;
      busy <= 1'b0; done <= 1'b0;
      wr_cnt <= '0; rd_idx <= '0; step_cnt <= '0;
    end else begin
      done <= fin;
      if (seg_valid && seg_ready) wr_cnt <= wr_cnt + 1'b1;
      if (start && !busy && wr_cnt != '0) begin
        busy <= 1'b1; rd_idx <= '0; step_cnt <= '0;
      end
      if (seg_end) begin
        acc_o    <= fin ? '0 : m_ea[ci];
        vel_o    <= fin ? '0 : m_ev[ci];
        pos_o    <= m_ep[ci];
        step_cnt <= '0;
        rd_idx   <= rd_idx + 1'b1;
        if (fin) begin busy <= 1'b0; wr_cnt <= '0; end
      end else if (adv) begin
        acc_o <= a_nx; vel_o <= v_nx; pos_o <= p_nx;
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && acc_o == '0 && vel_o == '0 && seg_ready));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(pos_o) && $stable(vel_o) && $stable(acc_o)));

  // R4
  hold_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_en && !skip) |=> ($stable(pos_o) && $stable(vel_o) && $stable(acc_o)));

  // R3
  start_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && wr_cnt == '0) |=> !busy);
endmodule

// File: tb/tb_traj_integrator.sv
`timescale 1ns/1ps
module tb_traj_integrator;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, seg_valid, seg_ready, start, cyc_en, busy, done;
  logic [1:0] seg_type;
  logic [31:0] seg_value, seg_end_acc, seg_end_vel;
  logic [15:0] seg_dur;
  logic [47:0] seg_end_pos;
  logic signed [31:0] acc_o, vel_o;
  logic signed [47:0] pos_o;

  traj_integrator dut (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;
  longint ma, mv, mp;

  // type, value, duration, end acc, end vel, end pos
  localparam longint PROF [0:4][0:5] = '{
    '{0,  3, 3,  9, 18,  31},
    '{1,  9, 2,  9, 36,  70},
    '{0, -3, 0,  5, 40, 100},
    '{2, 40, 3,  0, 40, 200},
    '{0, -4, 2, -8, 28, 270}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " acc"}, longint'(acc_o), ma);
    chk({req, " vel"}, longint'(vel_o), mv);
    chk({req, " pos"}, longint'(pos_o), mp);
  endtask

  task automatic load(input longint t, v, d, ea, ev, ep);
    @(negedge clk);
    seg_type = 2'(t); seg_value = 32'(v); seg_dur = 16'(d);
    seg_end_acc = 32'(ea); seg_end_vel = 32'(ev); seg_end_pos = 48'(ep);
    seg_valid = 1'b1;
    chk("R2 ready while loading", longint'(seg_ready), 1);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk); cyc_en = 1'b1;
    @(negedge clk); cyc_en = 1'b0;
  endtask

  task automatic model(input longint t, v);
    case (t)
      0: begin ma = ma + v; mv = mv + ma; mp = mp + mv; end
      1: begin ma = v; mv = mv + v; mp = mp + mv; end
      default: begin ma = 0; mv = v; mp = mp + v; end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; seg_valid = 0; start = 0; cyc_en = 0;
    seg_type = 0; seg_value = 0; seg_dur = 0;
    seg_end_acc = 0; seg_end_vel = 0; seg_end_pos = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ma = 0; mv = 0; mp = 0;
    // R1
    chk_state("R1 reset");
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 ready", longint'(seg_ready), 1);

    // R3: start with empty store
    pulse_start;
    chk("R3 empty start", longint'(busy), 0);
    // R4: cyc_en while idle
    step;
    chk_state("R4 idle strobe");

    for (int s = 0; s < 5; s++)
      load(PROF[s][0], PROF[s][1], PROF[s][2], PROF[s][3], PROF[s][4], PROF[s][5]);
    pulse_start;
    chk("R3 start busy", longint'(busy), 1);
    repeat (3) @(negedge clk);
    chk_state("R4 no strobe");
    seg_valid = 1'b1;
    chk("R2 ready low busy", longint'(seg_ready), 0);
    @(negedge clk); seg_valid = 1'b0;

    for (int s = 0; s < 5; s++) begin
      if (s == 3) begin
        pulse_start;
        chk_state("R3 start while busy");
      end
      if (PROF[s][2] == 0) begin
        @(posedge clk); @(negedge clk);
        ma = PROF[s][3]; mv = PROF[s][4]; mp = PROF[s][5];
        chk_state("R9 zero length skip");
      end else begin
        for (int i = 0; i < PROF[s][2]; i++) begin
          step;
          if (i == PROF[s][2] - 1) begin
            ma = PROF[s][3]; mv = PROF[s][4]; mp = PROF[s][5];
            if (s == 4) begin ma = 0; mv = 0; end
            chk_state(s == 4 ? "R10 final" : "R8 end load");
          end else begin
            model(PROF[s][0], PROF[s][1]);
            chk_state(PROF[s][0] == 0 ? "R5 jerk step" :
                      PROF[s][0] == 1 ? "R6 acc step" : "R7 vel step");
          end
        end
      end
    end
    chk("R10 done", longint'(done), 1);
    chk("R10 busy low", longint'(busy), 0);
    chk("R10 ready back", longint'(seg_ready), 1);
    @(negedge clk);
    chk("R10 done one clock", longint'(done), 0);
    chk_state("R10 hold");

    // R2: fill store, ninth offer ignored
    for (int k = 0; k < 8; k++) load(2, k + 1, 1, 0, k + 1, 10 * (k + 1));
    chk("R2 full ready", longint'(seg_ready), 0);
    @(negedge clk);
    seg_type = 2; seg_value = 99; seg_dur = 1; seg_end_pos = 999; seg_valid = 1'b1;
    @(negedge clk); seg_valid = 1'b0;
    pulse_start;
    for (int k = 0; k < 8; k++) step;
    chk("R2 ninth ignored pos", longint'(pos_o), 80);
    chk("R2 ninth ignored done", longint'(done), 1);
    pulse_start;
    chk("R3 emptied start", longint'(busy), 0);

    // R9: zero-length last segment ends the profile
    load(2, 7, 2, 0, 7, 14);
    load(0, 5, 0, 0, 0, 20);
    pulse_start;
    step;
    chk("R7 vel step pos", longint'(pos_o), 87);
    step;
    chk("R8 end pos", longint'(pos_o), 14);
    @(posedge clk); @(negedge clk);
    chk("R9 skip done", longint'(done), 1);
    chk("R9 skip pos", longint'(pos_o), 20);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule